// File: doc/BRIEF.md
# Receiver Sample-Delay Training Sweep

This block finds a good sampling delay for a receiver that has no clock travelling with its data. On a training request it steps a candidate delay from zero up to a parameterised maximum. For each candidate it asks the link to send one known test frame. It counts how many received words matched the word that was sent. A step passes only when every word of the frame matched.

When the sweep is over, the block looks at the runs of consecutive passing delays. It picks the widest run and programs the delay at the centre of that run. If no step passed, it reports a failure and keeps the delay it had before.

The link itself and the pattern memory are outside this block. The block drives the candidate delay and a one-cycle start pulse. It then receives a stream of per-word compare results and a transfer-done pulse.

Top module: `rx_phase_trainer`

## Requirements
- R1: After reset, `delay_out` equals parameter `INIT_DLY` (default 0), and `train_busy`, `train_done`, `train_fail` and `xfer_start` are all low.
- R2: A `train_req` pulse while idle starts a sweep of `MAX_DLY+1` test transfers, at delays 0, 1, … `MAX_DLY` in ascending order. Each transfer is announced by a single-cycle `xfer_start`, and `xfer_delay` holds that transfer's candidate delay. The next transfer is started only after `xfer_done` of the current one.
- R3: A step passes only when the number of cycles with both `cmp_valid` and `cmp_match` high, from the cycle after `xfer_start` up to and including the `xfer_done` cycle, equals exactly `WORDS`. A partial count (for example `WORDS-1`, or half) is a failing step.
- R4: The chosen delay is `first + (len-1)/2`, where `first` is the lowest delay of the chosen passing run and `len` is its length (integer division, so an even-length run takes the lower of its two middle values).
- R5: When several separate passing runs exist, the longest one is chosen; among equal lengths, the one with the lowest delays wins.
- R6: If no step passes, `train_fail` and `train_done` go high together and `delay_out` keeps its previous value.
- R7: `delay_out` changes only in the cycle in which `train_busy` falls at the end of a sweep. It is stable during the whole sweep and between sweeps.
- R8: A `train_req` arriving while a sweep is running is ignored: the sweep continues, the total number of transfers stays `MAX_DLY+1`, and the result is unaffected.
- R9: `train_done` rises in the same cycle that `train_busy` falls, stays high until the next accepted `train_req`, and is cleared together with `train_fail` when that request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_req | input | 1 | Pulse requesting a training sweep |
| xfer_start | output | 1 | One-cycle trigger for a test transfer |
| xfer_delay | output | DW | Candidate delay for the current transfer |
| cmp_valid | input | 1 | A per-word compare result is present |
| cmp_match | input | 1 | The received word equalled the sent word |
| xfer_done | input | 1 | The current test transfer has finished |
| delay_out | output | DW | Selected receiver delay |
| train_busy | output | 1 | Sweep in progress |
| train_done | output | 1 | Last sweep finished |
| train_fail | output | 1 | Last sweep found no passing delay |

## Verification
The bench models the link. It answers each transfer with a pattern of full, near-full or half match counts, chosen per delay from a mask set by each scenario.

Several inputs are used:
- A single odd-width window checks the centre arithmetic.
- An even-width window checks the lower-middle rounding.
- Two windows of unequal width separate "widest" from "first".
- Two windows of equal width separate tie-break-to-lowest from tie-break-to-last.
- A window touching the top delay checks the end of the range.
- An all-pass sweep checks the full range.
- An all-near-full sweep checks that a partial match never counts as a pass. It also checks that failure keeps the old delay.
- A request injected mid-sweep shows whether a second request restarts or disturbs the sweep.

// File: rtl/rxt_pkg.sv
// Shared types for the receiver delay trainer.
// Assumes: nothing beyond a standard SystemVerilog tool flow.
package rxt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_WAIT   = 3'd2,
        ST_JUDGE  = 3'd3,
        ST_FINISH = 3'd4
    } rxt_state_t;
endpackage

// File: rtl/rxt_tally.sv
// Match tally for one test transfer: counts matching words and reports
// whether exactly WORDS matches were seen.
// Assumes: clear is pulsed before each transfer; count saturates above WORDS
// so an overlong stream never wraps back to a full count.
module rxt_tally #(
    parameter int WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    output logic full
);
    localparam int CW = $clog2(WORDS + 2);
    localparam logic [CW-1:0] TOP  = CW'(WORDS + 1);
    localparam logic [CW-1:0] GOAL = CW'(WORDS);

    logic [CW-1:0] cnt_q;

    // Count hits, saturating one past the goal.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (hit && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == GOAL);
endmodule

// File: rtl/rxt_window.sv
// Passing-run tracker: follows the current run of passing delays and keeps
// the longest run so far; ties keep the earlier (lower) run.
// Assumes: steps arrive in ascending order, one judge pulse per step.
module rxt_window #(
    parameter int DW = 4,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          judge,
    input  logic          pass,
    input  logic [DW-1:0] step,
    output logic          found,
    output logic [DW-1:0] centre
);
    logic [DW-1:0] run_first_q, best_first_q;
    logic [LW-1:0] run_len_q, best_len_q;
    logic [DW-1:0] run_first_nx;
    logic [LW-1:0] run_len_nx;
    logic [LW-1:0] half_len;

    // Next value of the current run if this step passes.
    always_comb begin
        run_first_nx = (run_len_q == '0) ? step : run_first_q;
        run_len_nx   = run_len_q + 1'b1;
    end

    // Update current run and best run on each judged step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_first_q  <= '0;
            run_len_q    <= '0;
            best_first_q <= '0;
            best_len_q   <= '0;
        end else if (judge) begin
            if (pass) begin
                run_first_q <= run_first_nx;
                run_len_q   <= run_len_nx;
                if (run_len_nx > best_len_q) begin
                    best_first_q <= run_first_nx;
                    best_len_q   <= run_len_nx;
                end
            end else begin
                run_len_q <= '0;
            end
        end
    end

    // Centre of the best run, lower middle for even lengths.
    always_comb begin
        half_len = (best_len_q - 1'b1) >> 1;
        found    = (best_len_q != '0);
        centre   = best_first_q + half_len[DW-1:0];
    end
endmodule

// File: rtl/rx_phase_trainer.sv
// Receiver sample-delay training sweep. Steps a candidate delay over
// 0..MAX_DLY, runs one test transfer per step, and programs the centre of
// the widest fully matching run of delays.
// Assumes: the link answers every xfer_start with compare results followed
// by exactly one xfer_done pulse; results before the cycle after
// xfer_start are not counted.
module rx_phase_trainer #(
    parameter int MAX_DLY  = 15,
    parameter int WORDS    = 32,
    parameter int INIT_DLY = 0,
    parameter int DW       = $clog2(MAX_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          train_req,
    output logic          xfer_start,
    output logic [DW-1:0] xfer_delay,
    input  logic          cmp_valid,
    input  logic          cmp_match,
    input  logic          xfer_done,
    output logic [DW-1:0] delay_out,
    output logic          train_busy,
    output logic          train_done,
    output logic          train_fail
);
    import rxt_pkg::*;

    localparam int LW = $clog2(MAX_DLY + 2);
    localparam logic [DW-1:0] LAST = DW'(MAX_DLY);

    rxt_state_t    state_q;
    logic [DW-1:0] step_q;
    logic [DW-1:0] delay_q;
    logic          busy_q, done_q, fail_q;
    logic          step_full, win_found;
    logic [DW-1:0] win_centre;
    logic          accept, judging;

    assign accept  = (state_q == ST_IDLE) && train_req;
    assign judging = (state_q == ST_JUDGE);

    rxt_tally #(.WORDS(WORDS)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_LAUNCH),
        .hit   ((state_q == ST_WAIT) && cmp_valid && cmp_match),
        .full  (step_full)
    );

    rxt_window #(.DW(DW), .LW(LW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .judge  (judging),
        .pass   (step_full),
        .step   (step_q),
        .found  (win_found),
        .centre (win_centre)
    );

    // Sweep sequencer: launch, wait, judge per step, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            delay_q <= DW'(INIT_DLY);
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (train_req) begin
                        step_q  <= '0;
                        busy_q  <= 1'b1;
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (xfer_done) state_q <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    if (step_q == LAST) begin
                        state_q <= ST_FINISH;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_FINISH: begin
                    if (win_found) delay_q <= win_centre;
                    else           fail_q  <= 1'b1;
                    done_q  <= 1'b1;
                    busy_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign xfer_start = (state_q == ST_LAUNCH);
    assign xfer_delay = step_q;
    assign delay_out  = delay_q;
    assign train_busy = busy_q;
    assign train_done = done_q;
    assign train_fail = fail_q;
endmodule

// File: rtl/rxt_checker.sv
// Property checker for rx_phase_trainer, attached by bind.
// Assumes: reset is held low from time zero until the first edges.
module rxt_checker #(
    parameter int MAX_DLY = 15,
    parameter int DW      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic [DW-1:0] xfer_delay,
    input logic [DW-1:0] delay_out,
    input logic          train_busy,
    input logic          train_done,
    input logic          train_fail
);
    p_start_in_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (train_busy && (int'(xfer_delay) <= MAX_DLY)));

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    p_fail_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        train_fail |-> train_done);

    p_fail_keeps_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_fail) |-> $stable(delay_out));

    p_delay_moves_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delay_out) |-> $fell(train_busy));

    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        train_done |-> !train_busy);

    p_done_rises_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_done) |-> $fell(train_busy));
endmodule

bind rx_phase_trainer rxt_checker #(.MAX_DLY(MAX_DLY), .DW(DW)) i_rxt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_delay (xfer_delay),
    .delay_out  (delay_out),
    .train_busy (train_busy),
    .train_done (train_done),
    .train_fail (train_fail)
);

// File: tb/test_rx_phase_trainer.sv
// Directed bench: a link model answers each test transfer using per-delay
// masks; each scenario task checks its own results.
module test_rx_phase_trainer;
    localparam int MAX_DLY = 15;
    localparam int WORDS   = 32;
    localparam int DW      = 4;
    localparam int NSTEP   = MAX_DLY + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          train_req = 1'b0;
    logic          xfer_start;
    logic [DW-1:0] xfer_delay;
    logic          cmp_valid = 1'b0;
    logic          cmp_match = 1'b0;
    logic          xfer_done = 1'b0;
    logic [DW-1:0] delay_out;
    logic          train_busy, train_done, train_fail;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Link model state.
    logic [NSTEP-1:0] pass_mask = '0;
    logic [NSTEP-1:0] near_mask = '0;
    int starts_seen = 0;
    bit order_ok = 1'b1;
    bit hold_ok  = 1'b1;
    logic [DW-1:0] held_delay = '0;

    always #4 clk = ~clk;

    rx_phase_trainer #(.MAX_DLY(MAX_DLY), .WORDS(WORDS), .INIT_DLY(0)) i_rx_phase_trainer (
        .clk(clk), .rst_n(rst_n), .train_req(train_req),
        .xfer_start(xfer_start), .xfer_delay(xfer_delay),
        .cmp_valid(cmp_valid), .cmp_match(cmp_match), .xfer_done(xfer_done),
        .delay_out(delay_out), .train_busy(train_busy),
        .train_done(train_done), .train_fail(train_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Link model: answers every start pulse with WORDS results and a done.
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_start) begin
                automatic int d = int'(xfer_delay);
                if (d != starts_seen) order_ok = 1'b0;
                starts_seen++;
                @(negedge clk);
                for (int w = 0; w < WORDS; w++) begin
                    cmp_valid = 1'b1;
                    if (pass_mask[d])      cmp_match = 1'b1;
                    else if (near_mask[d]) cmp_match = (w != 0);
                    else                   cmp_match = w[0];
                    if (delay_out != held_delay || int'(xfer_delay) != d) hold_ok = 1'b0;
                    @(negedge clk);
                end
                cmp_valid = 1'b0;
                cmp_match = 1'b0;
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    // Runs one sweep and checks the outcome against expected values.
    task automatic run_sweep(input string name, input logic [NSTEP-1:0] pm,
                             input logic [NSTEP-1:0] nm, input bit exp_fail,
                             input int exp_dly, input bit poke_mid);
        pass_mask   = pm;
        near_mask   = nm;
        starts_seen = 0;
        order_ok    = 1'b1;
        hold_ok     = 1'b1;
        held_delay  = delay_out;
        @(negedge clk);
        train_req = 1'b1;
        @(negedge clk);
        train_req = 1'b0;
        // R9: request accepted clears done and fail
        chk(train_busy && !train_done && !train_fail, {name, " R9 start state"},
            {train_busy, train_done, train_fail}, 3'b100);
        if (poke_mid) begin
            repeat (100) @(negedge clk);
            train_req = 1'b1;
            @(negedge clk);
            train_req = 1'b0;
        end
        while (train_busy) @(negedge clk);
        chk(starts_seen == NSTEP, {name, " R2 R8 transfer count"}, starts_seen, NSTEP);
        chk(order_ok, {name, " R2 ascending delays"}, order_ok, 1);
        chk(hold_ok, {name, " R7 delay stable in sweep"}, hold_ok, 1);
        chk(train_done == 1'b1, {name, " R9 done"}, train_done, 1);
        chk(train_fail == exp_fail, {name, " R6 fail flag"}, train_fail, exp_fail);
        chk(int'(delay_out) == exp_dly, {name, " R4 R5 R6 chosen delay"}, delay_out, exp_dly);
        repeat (5) @(negedge clk);
        // R9 R7: done and delay held while idle
        chk(train_done && int'(delay_out) == exp_dly, {name, " R9 R7 held idle"},
            delay_out, exp_dly);
    endtask

    task automatic t_reset();
        // R1: reset values
        chk(delay_out == '0, "R1 delay", delay_out, 0);
        chk(!train_busy && !train_done && !train_fail && !xfer_start, "R1 flags",
            {train_busy, train_done, train_fail, xfer_start}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R4: odd window 5..9 -> 7
        run_sweep("odd_win", 16'h03E0, '0, 1'b0, 7, 1'b0);
        // R4: even window 4..7 -> 5
        run_sweep("even_win", 16'h00F0, '0, 1'b0, 5, 1'b0);
        // R5: widest of 1..2 and 8..12 -> 10
        run_sweep("widest", 16'h1F06, '0, 1'b0, 10, 1'b0);
        // R5: tie 0..2 and 10..12 -> 1
        run_sweep("tie_low", 16'h1C07, '0, 1'b0, 1, 1'b0);
        // R3 R6: near-full everywhere fails, delay stays 1
        run_sweep("partial", '0, 16'hFFFF, 1'b1, 1, 1'b0);
        // R3: near-full around a window 13..15 -> 14
        run_sweep("top_edge", 16'hE000, 16'h1FFF, 1'b0, 14, 1'b0);
        // R4: all pass -> 7
        run_sweep("all_pass", 16'hFFFF, '0, 1'b0, 7, 1'b0);
        // R8: extra request mid sweep, window 2..6 -> 4
        run_sweep("req_busy", 16'h007C, '0, 1'b0, 4, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule